// File: doc/BRIEF.md
# Receive Character Word Packer

This block sits between a link receiver and a receive FIFO. It accepts one character per handshake from the link side. Each character is a data byte or an end-of-packet marker, and a marker byte whose bit 0 is 0 is a normal end while bit 0 set to 1 is an error end. The block packs the characters into words of four byte lanes. The first character of a word goes in the most significant lane. When a word is complete, the block offers it to the FIFO with a valid/ready handshake. A DMA engine that drains the FIFO finds where each packet ended from the per-lane flag bits, so it can compute the packet length without scanning bytes.

A word is complete when four characters have been taken or when a marker arrives. A marker closes the word at its own lane, sets that lane's flag and leaves every later lane zero. Back-pressure rules:
- A character transfers on a clock edge where `in_valid` and `in_ready` are both high.
- A word transfers on an edge where `out_valid` and `out_ready` are both high.
- `in_ready` follows `out_ready`, so a full FIFO stalls the source and the partial word waits in place.
- A word already offered stays on `out_data`, unchanged, until the FIFO accepts it.

Top module: `char_packer`

## Requirements
- R1: A synchronous active-low reset clears `out_valid`, returns the lane position to the first lane and discards any partial word; the next four data bytes form a word of their own.
- R2: Data bytes fill the lanes in arrival order: the first goes in `out_data[31:24]`, then `[23:16]`, then `[15:8]`, then `[7:0]`.
- R3: A word with only data is offered only after its fourth byte has been taken; `out_valid` stays low while fewer lanes are filled.
- R4: A marker taken in lane k (k = 0 for bits 31:24 up to k = 3 for bits 7:0) closes the word at once and sets flag bit 35−k. All lanes after k are zero. The next character starts a new word in lane 0.
- R5: The marker byte is stored unchanged in its lane, so bit 0 of the lane is 0 for a normal end and 1 for an error end. Each word has at most one flag set, and the flag belongs to the last valid lane.
- R6: While `out_ready` is low, `in_ready` is low, no character is taken and the partial word is kept intact.
- R7: Once `out_valid` is high, it stays high with `out_data` stable until a cycle in which `out_ready` is high.
- R8: With `out_ready` held high, a character is taken on every cycle, including the cycle in which a completed word is handed to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Character present on `in_char` |
| in_ready | output | 1 | Block can take a character this cycle |
| in_char | input | 8 | Data byte, or marker byte (bit 0: 0 normal end, 1 error end) |
| in_eop | input | 1 | 1 = `in_char` is an end-of-packet marker |
| out_valid | output | 1 | A completed word is on `out_data` |
| out_ready | input | 1 | FIFO can accept a word (low when full) |
| out_data | output | 36 | Bits 35:32 lane flags (35 for the first lane), bits 31:0 lanes |

## Verification
The packer is tried with runs of four plain data bytes, which show the lane order. It is also tried with packets that end in each of the four lanes, using both normal and error marker bytes. These show where each flag goes, that later lanes are zero, and that the marker byte keeps its value. Streams sent without gaps show whether the block drops a cycle at word boundaries. FIFO-full periods placed in the middle of a word and in the middle of an offered word show that the partial word and the offered word are both kept. A reset in the middle of a word shows that the leftover bytes are discarded rather than merged into the next word.

// File: rtl/packer_pkg.sv
package packer_pkg;
  // Bit index of the least significant bit of byte lane k (lane 0 is the most significant).
  function automatic int lane_lsb(input int k, input int lanes, input int cw);
    return (lanes - 1 - k) * cw;
  endfunction

  // Bit index of the flag belonging to lane k, above the data field.
  function automatic int flag_bit(input int k, input int lanes, input int cw);
    return lanes * cw + (lanes - 1 - k);
  endfunction
endpackage

// File: rtl/pk_lane_ctr.sv
module pk_lane_ctr #(
  parameter int LANES = 4,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          close,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = (idx == IW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (take) begin
      if (close) idx <= '0;
      else       idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pk_lane_bank.sv
module pk_lane_bank
  import packer_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW = 8,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DW = LANES * CW,
  localparam int WW = DW + LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          close,
  input  logic [IW-1:0] idx,
  input  logic [CW-1:0] char_in,
  input  logic          eop_in,
  output logic [WW-1:0] word
);
  logic [CW-1:0] lane_q [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LSB = lane_lsb(k, LANES, CW);
    localparam int FB  = flag_bit(k, LANES, CW);
    logic here;
    assign here = (idx == IW'(k));

    // Lanes after the current one are always zero, so a closing word needs no extra masking.
    always_ff @(posedge clk) begin
      if (!rst_n || (take && close)) lane_q[k] <= '0;
      else if (take && here)        lane_q[k] <= char_in;
    end

    assign word[LSB +: CW] = here ? char_in : lane_q[k];
    assign word[FB]        = here & eop_in;
  end
endmodule

// File: rtl/pk_out_reg.sv
module pk_out_reg #(
  parameter int WW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] d,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [WW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/char_packer.sv
module char_packer #(
  parameter int LANES = 4,
  parameter int CW = 8,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW = LANES * CW + LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_char,
  input  logic          in_eop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_data
);
  logic          take;
  logic          close;
  logic          last;
  logic [IW-1:0] idx;
  logic [WW-1:0] word;

  // The offered word drains in the same cycle a new one may be loaded, so readiness tracks the FIFO alone.
  assign in_ready = out_ready;
  assign take     = in_valid & in_ready;
  assign close    = in_eop | last;

  pk_lane_ctr #(.LANES(LANES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .take(take), .close(close), .idx(idx), .last(last)
  );

  pk_lane_bank #(.LANES(LANES), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .take(take), .close(close), .idx(idx),
    .char_in(in_char), .eop_in(in_eop), .word(word)
  );

  pk_out_reg #(.WW(WW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(take & close), .d(word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/packer_checker.sv
module packer_checker #(
  parameter int LANES = 4,
  parameter int CW = 8,
  localparam int DW = LANES * CW,
  localparam int WW = DW + LANES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [WW-1:0] out_data
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r6_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_data[WW-1:DW]));

  for (genvar k = 0; k < LANES - 1; k++) begin : g_tail
    localparam int TAIL_W = (LANES - 1 - k) * CW;
    localparam logic [DW-1:0] TAIL = {DW{1'b1}} >> (DW - TAIL_W);
    a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_data[DW + LANES - 1 - k] |-> (out_data[DW-1:0] & TAIL) == '0);
  end
endmodule

bind char_packer packer_checker #(.LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_char_packer.sv
`timescale 1ns/100ps
module tb_char_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_char;
  logic        in_eop;
  logic        out_valid;
  logic        out_ready;
  logic [35:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [35:0] cap [0:63];
  int cap_n = 0;

  always #2.5 clk = ~clk;

  char_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) cycles <= cycles + 1;

  // FIFO model: record every word that transfers at the coming edge.
  always @(negedge clk)
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_data;
      cap_n = cap_n + 1;
    end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic e);
    in_valid = 1'b1; in_char = c; in_eop = e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    check("R1 out_valid after reset", 36'(out_valid), 36'd0);
    check("R6 in_ready follows out_ready", 36'(in_ready), 36'(out_ready));
  endtask

  task automatic t_data_word();
    int base = cap_n;
    send(8'hA1, 0); send(8'hB2, 0); send(8'hC3, 0);
    check("R3 no word after three bytes", 36'(out_valid), 36'd0);
    send(8'hD4, 0);
    check("R3 word offered after fourth byte", 36'(out_valid), 36'd1);
    settle();
    check("R3 one word written", 36'(cap_n - base), 36'd1);
    check("R2 lane order", cap[base], 36'h0_A1B2C3D4);
  endtask

  task automatic t_markers();
    int base = cap_n;
    send(8'h00, 1);
    send(8'h11, 0); send(8'h00, 1);
    send(8'h21, 0); send(8'h22, 0); send(8'h01, 1);
    send(8'h31, 0); send(8'h32, 0); send(8'h33, 0); send(8'h00, 1);
    send(8'h41, 0); send(8'h42, 0); send(8'h43, 0); send(8'h01, 1);
    send(8'h51, 0); send(8'h52, 0); send(8'h53, 0); send(8'h54, 0);
    settle();
    check("R4 word count", 36'(cap_n - base), 36'd6);
    check("R4 marker lane0 flag35", cap[base],   36'h8_00000000);
    check("R4 marker lane1 flag34", cap[base+1], 36'h4_11000000);
    check("R5 error marker lane2",  cap[base+2], 36'h2_21220100);
    check("R4 marker lane3 flag32", cap[base+3], 36'h1_31323300);
    check("R5 error marker lane3",  cap[base+4], 36'h1_41424301);
    check("R4 restart at lane0",    cap[base+5], 36'h0_51525354);
  endtask

  task automatic t_stream();
    int base = cap_n;
    int c0;
    c0 = cycles;
    for (int i = 0; i < 8; i++) send(8'(8'h60 + i), 0);
    check("R8 eight chars in eight cycles", 36'(cycles - c0), 36'd8);
    settle();
    check("R8 first word", cap[base], 36'h0_60616263);
    check("R8 second word", cap[base+1], 36'h0_64656667);
  endtask

  task automatic t_stall_partial();
    int base = cap_n;
    send(8'h71, 0); send(8'h72, 0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_char = 8'h73; in_eop = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 in_ready low when full", 36'(in_ready), 36'd0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    send(8'h73, 0); send(8'h00, 1);
    settle();
    check("R6 partial word kept", cap[base], 36'h1_71727300);
    check("R6 single word", 36'(cap_n - base), 36'd1);
  endtask

  task automatic t_hold_offer();
    int base = cap_n;
    send(8'h81, 0); send(8'h82, 0); send(8'h83, 0); send(8'h84, 0);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 valid held", 36'(out_valid), 36'd1);
      check("R7 data held", out_data, 36'h0_81828384);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    settle();
    check("R7 written once after release", 36'(cap_n - base), 36'd1);
    check("R7 released word", cap[base], 36'h0_81828384);
  endtask

  task automatic t_reset_mid_word();
    int base = cap_n;
    send(8'h55, 0); send(8'h66, 0);
    do_reset();
    check("R1 no word after reset", 36'(out_valid), 36'd0);
    send(8'h01, 0); send(8'h02, 0); send(8'h03, 0); send(8'h04, 0);
    settle();
    check("R1 partial discarded", cap[base], 36'h0_01020304);
    check("R1 one word", 36'(cap_n - base), 36'd1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_char = '0; in_eop = 1'b0; out_ready = 1'b1;
    do_reset();
    t_reset_state();
    t_data_word();
    t_markers();
    t_stream();
    t_stall_partial();
    t_hold_offer();
    t_reset_mid_word();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule